// File: doc/BRIEF.md
# SPI Master Serial Clock Generator

This block produces the serial clock of an SPI master from the system clock, together with two single-cycle strobes. The sample strobe marks the edges on which the data path captures incoming bits. The shift strobe marks the edges on which it drives the next outgoing bit. A power-of-two prescaler turns the system clock into a base tick. Each SCK phase then lasts a separately programmed number of base ticks, one count for the high level and one for the low level, so the duty cycle need not be 50%.

Polarity and phase inputs select one of the four SPI modes. Polarity sets the level SCK rests at between transfers. Phase decides whether the first edge of each bit is a sample edge or a launch edge. A start pulse latches every setting and runs a transfer of the programmed number of bits. A stop pulse abandons the transfer at once. A drive-enable output is high only while this master owns the clock line, so the pad can be released when a different master is in control.

Top module: `spi_sck_gen`

## Requirements
- R1: Out of reset SCK is low and sck_oe, sample_stb and shift_stb are low. While no transfer runs, SCK takes the value of cfg_cpol one clock later and both strobes stay low.
- R2: The base tick period is 2^cfg_scale system clocks. Any cfg_scale value above 8 behaves exactly like 8.
- R3: A high SCK phase lasts cfg_hi base ticks and a low phase lasts cfg_lo base ticks. A count of 0 means 256 base ticks.
- R4: A transfer begins on the clock edge where start is accepted, with SCK at the idle level. The first SCK edge comes exactly 2^scale × (idle-level count) clocks after that edge.
- R5: With cfg_cpha = 0, the first edge of each bit raises sample_stb and the second raises shift_stb. With cfg_cpha = 1 the roles swap. Each strobe is one clock wide, appears in the same clock as the SCK change, and never occurs together with the other strobe.
- R6: A transfer of N bits (cfg_bits = N) makes exactly 2N SCK edges. SCK is back at the idle level after the last edge, and sck_oe falls on that same clock. A start with cfg_bits = 0 is ignored.
- R7: A stop while a transfer runs ends it on the next clock: sck_oe falls, SCK takes the cfg_cpol level, and no further strobe appears.
- R8: Changes to cfg_scale, cfg_hi, cfg_lo, cfg_cpha and cfg_bits during a transfer, and any start pulse during a transfer, have no effect on the running transfer. New settings apply at the next accepted start.
- R9: When start and stop are both high in the same clock while no transfer runs, no transfer begins.
- R10: sck_oe is high from the clock after a start is accepted until the transfer ends or is stopped, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_scale | input | 4 | Prescaler exponent; the base tick is clk / 2^scale, with values above 8 clamped |
| cfg_hi | input | 8 | SCK high-phase length in base ticks (0 = 256) |
| cfg_lo | input | 8 | SCK low-phase length in base ticks (0 = 256) |
| cfg_cpol | input | 1 | Idle level of SCK |
| cfg_cpha | input | 1 | 0: sample on the first edge of a bit, 1: sample on the second edge |
| cfg_bits | input | 6 | Number of bits in the transfer |
| start | input | 1 | Begin a transfer (accepted only while idle) |
| stop | input | 1 | Abandon the current transfer |
| sck | output | 1 | Serial clock |
| sck_oe | output | 1 | High while this master drives SCK |
| sample_stb | output | 1 | One-clock pulse on each sampling edge |
| shift_stb | output | 1 | One-clock pulse on each launch edge |

## Verification
The assertions assume that start and stop are synchronous pulses and that the settings are stable at the clock edge where a start is accepted. They make no assumption about when the settings change at other times. The stimulus changes inputs only on falling clock edges, so every setting and control input is settled at the rising edge that samples it. It also deliberately changes the settings and pulses start in the middle of a transfer, so that the latching rule is tested rather than assumed. Phase counts and scales are kept small enough that a worst-case 256-tick phase is reached only with a one-clock base tick.

// File: rtl/spi_sck_pkg.sv
package spi_sck_pkg;

  // Which half of the current bit the generator is in
  typedef enum logic {
    HALF_LEAD  = 1'b0,
    HALF_TRAIL = 1'b1
  } half_e;

  // Strobe pair emitted on an SCK edge
  typedef struct packed {
    logic sample;
    logic shift;
  } stb_t;

  // Strobe kind for an edge: lead edge samples when cpha is 0, trail edge samples when cpha is 1
  function automatic stb_t edge_role(input half_e half, input logic cpha);
    stb_t s;
    s.sample = (half == HALF_LEAD) ? ~cpha : cpha;
    s.shift  = ~s.sample;
    return s;
  endfunction

endpackage

// File: rtl/spi_sck_prescaler.sv
module spi_sck_prescaler #(
  parameter int SCALE_W   = 4,
  parameter int MAX_SCALE = 8,
  localparam int PRE_W    = (MAX_SCALE > 0) ? MAX_SCALE : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               clr,
  input  logic [SCALE_W-1:0] scale,
  output logic               tick
);

  localparam logic [SCALE_W-1:0] SCALE_CAP = SCALE_W'(MAX_SCALE);

  logic [SCALE_W-1:0] eff_scale;
  logic [PRE_W:0]     div_w;
  logic [PRE_W:0]     div_m1_w;
  logic [PRE_W-1:0]   terminal;
  logic [PRE_W-1:0]   cnt_q, cnt_d;

  // Clamp the exponent, then derive the last count value of one base period
  always_comb begin
    eff_scale = (scale > SCALE_CAP) ? SCALE_CAP : scale;
    div_w     = {{PRE_W{1'b0}}, 1'b1} << eff_scale;
    div_m1_w  = div_w - {{PRE_W{1'b0}}, 1'b1};
    terminal  = div_m1_w[PRE_W-1:0];
  end

  always_comb begin
    tick  = run && (cnt_q == terminal);
    cnt_d = cnt_q;
    if (clr || !run) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R2: the divider count never passes the end of a base period
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= terminal));

  // R2: an idle divider rests at zero
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/spi_sck_phase_timer.sv
module spi_sck_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] len_code,
  output logic             expire
);

  logic [CNT_W-1:0] len_m1;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // A code of zero wraps to all ones, giving 2^CNT_W ticks
  always_comb begin
    len_m1 = len_code - 1'b1;
    expire = run && tick && (cnt_q == len_m1);
    cnt_d  = cnt_q;
    if (clr || !run) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = expire ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R3: a phase never counts beyond its programmed length
  a_r3_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= len_m1));

  // R3: the count restarts after each phase ends
  a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == '0));

endmodule

// File: rtl/spi_sck_wave.sv
module spi_sck_wave
  import spi_sck_pkg::*;
#(
  parameter int BIT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             expire,
  input  logic             cpol_live,
  input  logic             cpha_lat,
  input  logic [BIT_W-1:0] bits_live,
  output logic             accept,
  output logic             busy,
  output logic             sck,
  output logic             sample_stb,
  output logic             shift_stb
);

  logic             busy_q, busy_d;
  half_e            half_q, half_d;
  logic [BIT_W-1:0] left_q, left_d;
  logic             sck_q, sck_d;
  stb_t             stb_q, stb_d;
  stb_t             role;

  always_comb begin
    accept = start && !stop && !busy_q && (bits_live != '0);
    role   = edge_role(half_q, cpha_lat);
    busy_d = busy_q;
    half_d = half_q;
    left_d = left_q;
    sck_d  = sck_q;
    stb_d  = '0;
    if (!busy_q) begin
      sck_d = cpol_live;
      if (accept) begin
        busy_d = 1'b1;
        half_d = HALF_LEAD;
        left_d = bits_live;
      end
    end else if (stop) begin
      busy_d = 1'b0;
      sck_d  = cpol_live;
    end else if (expire) begin
      sck_d = ~sck_q;
      stb_d = role;
      if (half_q == HALF_LEAD) begin
        half_d = HALF_TRAIL;
      end else begin
        half_d = HALF_LEAD;
        left_d = left_q - 1'b1;
        if (left_q == {{(BIT_W-1){1'b0}}, 1'b1}) begin
          busy_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      half_q <= HALF_LEAD;
      left_q <= '0;
      sck_q  <= 1'b0;
      stb_q  <= '0;
    end else begin
      busy_q <= busy_d;
      half_q <= half_d;
      left_q <= left_d;
      sck_q  <= sck_d;
      stb_q  <= stb_d;
    end
  end

  assign busy       = busy_q;
  assign sck        = sck_q;
  assign sample_stb = stb_q.sample;
  assign shift_stb  = stb_q.shift;

  // R5: never both strobes at once
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb_q.sample && stb_q.shift));

  // R5: a strobe coincides with an SCK transition
  a_r5_strobe_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_q.sample || stb_q.shift) |-> (sck_q != $past(sck_q)));

  // R5: during a transfer SCK moves only together with a strobe
  a_r5_edge_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_q) && !$past(stop) && (sck_q != $past(sck_q))) |-> (stb_q.sample || stb_q.shift));

  // R1: no strobe outside a transfer
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !$past(busy_q)) |-> !(stb_q.sample || stb_q.shift));

  // R4: a transfer opens at the idle level
  a_r4_open_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (sck_q == $past(cpol_live)));

  // R7: stop ends a transfer on the next clock
  a_r7_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && stop) |=> (!busy_q && !stb_q.sample && !stb_q.shift));

  // R9: a stop at the same time as start keeps the block idle
  a_r9_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && start && stop) |=> !busy_q);

endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
  parameter int SCALE_W   = 4,
  parameter int MAX_SCALE = 8,
  parameter int CNT_W     = 8,
  parameter int BIT_W     = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SCALE_W-1:0] cfg_scale,
  input  logic [CNT_W-1:0]   cfg_hi,
  input  logic [CNT_W-1:0]   cfg_lo,
  input  logic               cfg_cpol,
  input  logic               cfg_cpha,
  input  logic [BIT_W-1:0]   cfg_bits,
  input  logic               start,
  input  logic               stop,
  output logic               sck,
  output logic               sck_oe,
  output logic               sample_stb,
  output logic               shift_stb
);

  logic rst_meta, rst_sync;

  // Assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic               accept, busy, tick, expire, sck_i;
  logic               restart;
  logic [SCALE_W-1:0] lat_scale;
  logic [CNT_W-1:0]   lat_hi, lat_lo;
  logic               lat_cpha;
  logic [CNT_W-1:0]   len_code;

  // Settings are captured only when a transfer is accepted
  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      lat_scale <= '0;
      lat_hi    <= '0;
      lat_lo    <= '0;
      lat_cpha  <= 1'b0;
    end else if (accept) begin
      lat_scale <= cfg_scale;
      lat_hi    <= cfg_hi;
      lat_lo    <= cfg_lo;
      lat_cpha  <= cfg_cpha;
    end
  end

  always_comb begin
    restart  = accept || stop;
    len_code = sck_i ? lat_hi : lat_lo;
  end

  spi_sck_prescaler #(
    .SCALE_W   (SCALE_W),
    .MAX_SCALE (MAX_SCALE)
  ) u_pre (
    .clk   (clk),
    .rst_n (rst_sync),
    .run   (busy),
    .clr   (restart),
    .scale (lat_scale),
    .tick  (tick)
  );

  spi_sck_phase_timer #(
    .CNT_W (CNT_W)
  ) u_phase (
    .clk      (clk),
    .rst_n    (rst_sync),
    .run      (busy),
    .clr      (restart),
    .tick     (tick),
    .len_code (len_code),
    .expire   (expire)
  );

  spi_sck_wave #(
    .BIT_W (BIT_W)
  ) u_wave (
    .clk        (clk),
    .rst_n      (rst_sync),
    .start      (start),
    .stop       (stop),
    .expire     (expire),
    .cpol_live  (cfg_cpol),
    .cpha_lat   (lat_cpha),
    .bits_live  (cfg_bits),
    .accept     (accept),
    .busy       (busy),
    .sck        (sck_i),
    .sample_stb (sample_stb),
    .shift_stb  (shift_stb)
  );

  assign sck    = sck_i;
  assign sck_oe = busy;

  // R8: captured settings hold for the whole transfer
  a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_sync)
    (busy && $past(busy)) |-> ($stable(lat_scale) && $stable(lat_hi) && $stable(lat_lo) && $stable(lat_cpha)));

  // R10: the drive enable rises only on an accepted start
  a_r10_oe_rise: assert property (@(posedge clk) disable iff (!rst_sync)
    $rose(sck_oe) |-> $past(accept));

endmodule

// File: tb/tb_spi_sck_gen.sv
`timescale 1ns/1ps
module tb_spi_sck_gen;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] cfg_scale;
  logic [7:0] cfg_hi, cfg_lo;
  logic       cfg_cpol, cfg_cpha;
  logic [5:0] cfg_bits;
  logic       start, stop;
  logic       sck, sck_oe, sample_stb, shift_stb;

  always #10 clk = ~clk;

  spi_sck_gen dut (
    .clk(clk), .rst_n(rst_n), .cfg_scale(cfg_scale), .cfg_hi(cfg_hi), .cfg_lo(cfg_lo),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_bits(cfg_bits), .start(start), .stop(stop),
    .sck(sck), .sck_oe(sck_oe), .sample_stb(sample_stb), .shift_stb(shift_stb)
  );

  typedef struct packed { logic sck; logic smp; logic sht; logic oe; } exp_t;

  exp_t  q[$];
  exp_t  cur;
  bit    model_en = 1'b0;
  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";

  // Behavioural reference: expand a transfer into its per-clock waveform
  task automatic build();
    int s, dv, hl, ll, d;
    bit lvl, ph, smp, oe;
    s   = (cfg_scale > 8) ? 8 : int'(cfg_scale);
    dv  = 1 << s;
    hl  = (cfg_hi == 0) ? 256 : int'(cfg_hi);
    ll  = (cfg_lo == 0) ? 256 : int'(cfg_lo);
    lvl = cfg_cpol;
    ph  = cfg_cpha;
    q.push_back(exp_t'{lvl, 1'b0, 1'b0, 1'b1});
    for (int b = 0; b < int'(cfg_bits); b++) begin
      for (int e = 0; e < 2; e++) begin
        d = dv * (lvl ? hl : ll);
        for (int k = 0; k < d - 1; k++) q.push_back(exp_t'{lvl, 1'b0, 1'b0, 1'b1});
        lvl = !lvl;
        smp = ((e == 0) == (ph == 1'b0));
        oe  = !((b == int'(cfg_bits) - 1) && (e == 1));
        q.push_back(exp_t'{lvl, smp, !smp, oe});
      end
    end
  endtask

  always @(posedge clk) begin
    if (model_en) begin
      if (q.size() != 0) begin
        if (stop) begin
          q.delete();
          cur = exp_t'{cfg_cpol, 1'b0, 1'b0, 1'b0};
        end else begin
          cur = q.pop_front();
        end
      end else if (start && !stop && cfg_bits != 0) begin
        build();
        cur = q.pop_front();
      end else begin
        cur = exp_t'{cfg_cpol, 1'b0, 1'b0, 1'b0};
      end
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (model_en) begin
      checks++;
      if ({sck, sample_stb, shift_stb, sck_oe} !== cur) begin
        errors++;
        $display("FAIL %s t=%0t actual sck/smp/sht/oe=%b expected=%b",
                 cur_req, $time, {sck, sample_stb, shift_stb, sck_oe}, cur);
      end
    end
  end

  task automatic set_cfg(input bit pol, input bit pha, input int sc, input int hi, input int lo, input int nb);
    cfg_cpol  = pol;
    cfg_cpha  = pha;
    cfg_scale = 4'(sc);
    cfg_hi    = 8'(hi);
    cfg_lo    = 8'(lo);
    cfg_bits  = 6'(nb);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int gap);
    while (q.size() != 0) @(negedge clk);
    repeat (gap) @(negedge clk);
  endtask

  task automatic xfer(input bit pol, input bit pha, input int sc, input int hi, input int lo,
                      input int nb, input int gap, input string req);
    cur_req = req;
    set_cfg(pol, pha, sc, hi, lo, nb);
    pulse_start();
    wait_done(gap);
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    stop  = 1'b0;
    set_cfg(1'b0, 1'b0, 0, 1, 1, 1);
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if ({sck, sample_stb, shift_stb, sck_oe} !== 4'b0000) begin
      errors++;
      $display("FAIL R1 reset actual=%b expected=0000", {sck, sample_stb, shift_stb, sck_oe});
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_en = 1'b1;
    repeat (2) @(negedge clk);

    // R1: idle level follows polarity
    cur_req = "R1";
    cfg_cpol = 1'b1;
    repeat (3) @(negedge clk);
    cfg_cpol = 1'b0;
    repeat (2) @(negedge clk);

    // R3 R4 R5 R6 R10: four modes, uneven duty
    xfer(1'b0, 1'b0, 0, 2, 3, 3, 3, "R3/R4/R5/R6/R10 mode0");
    xfer(1'b1, 1'b1, 1, 1, 4, 2, 3, "R3/R4/R5/R6 mode3");
    xfer(1'b0, 1'b1, 2, 3, 1, 2, 3, "R4/R5 mode1");
    xfer(1'b1, 1'b0, 0, 5, 2, 3, 3, "R4/R5 mode2");
    xfer(1'b0, 1'b0, 0, 1, 1, 4, 3, "R5 minimum phases");

    // R3: zero count means 256
    xfer(1'b0, 1'b0, 0, 0, 1, 1, 3, "R3 hi zero");
    xfer(1'b1, 1'b1, 0, 2, 0, 1, 3, "R3 lo zero");

    // R2: largest scale and clamping above it
    xfer(1'b0, 1'b0, 8, 1, 2, 1, 3, "R2 scale 8");
    xfer(1'b1, 1'b0, 12, 1, 1, 1, 3, "R2 scale clamp");
    xfer(1'b0, 1'b1, 3, 2, 2, 1, 3, "R2 scale 3");

    // R6: back-to-back transfers and zero-bit start
    xfer(1'b0, 1'b0, 0, 2, 2, 2, 0, "R6 back to back");
    xfer(1'b0, 1'b1, 1, 1, 2, 1, 3, "R6 second");
    xfer(1'b0, 1'b0, 0, 2, 2, 0, 6, "R6 zero bits");

    // R8: settings and start changed mid-transfer
    cur_req = "R8";
    set_cfg(1'b0, 1'b0, 1, 2, 2, 4);
    pulse_start();
    repeat (10) @(negedge clk);
    set_cfg(1'b1, 1'b1, 0, 5, 7, 1);
    pulse_start();
    repeat (4) @(negedge clk);
    wait_done(4);
    set_cfg(1'b0, 1'b0, 0, 1, 1, 1);
    repeat (3) @(negedge clk);

    // R7: abort mid-transfer
    cur_req = "R7";
    set_cfg(1'b1, 1'b0, 0, 3, 3, 4);
    pulse_start();
    repeat (9) @(negedge clk);
    cfg_cpol = 1'b0;
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    repeat (6) @(negedge clk);

    // R9: start and stop together
    cur_req = "R9";
    set_cfg(1'b0, 1'b0, 0, 1, 1, 2);
    start = 1'b1;
    stop  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    stop  = 1'b0;
    repeat (6) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule